// File: doc/BRIEF.md
# Nibble Bus Host Interface for a Time-of-Day Counter

This block is the host-facing front end of a time-of-day clock. A host talks to it over a 4-bit data path with a strobe that loads an address, a write strobe, a read strobe and two chip selects. The loaded address picks one of thirteen digit registers, which hold the seconds, minutes, hours, weekday, day, month and year digits and live in a counter chain outside this block. Writing one of these addresses sends a one-cycle write strobe and the data nibble to the counter chain. Reading one returns that digit on the bus.

Two further addresses act as commands and hold no data. Writing address 0xD clears the sub-second divider, which also clears the busy window. Reading 0xE or 0xF returns four live divided clocks.

The block also holds the prescaler. The prescaler is driven by an enable that pulses once per 32.768 kHz oscillator period. It produces a 1024 Hz square wave, a 1 Hz square wave, a once-per-minute square wave and a once-per-hour square wave. It also produces a once-per-second carry pulse for the counter chain and a busy flag. When chip select 1 is low the block is in data-holding mode: the bus is ignored, but the prescaler keeps counting. Every divide ratio is a parameter, so a bench can shrink the ratios.

Top module: `rtc_nibble_host`

## Requirements
- R1: After reset, the latched address is 0. The bus is not driven, busy_o is 0, and no write strobe or second carry is active.
- R2: On a rising edge of adr_wr_i while both chip selects are high, bus_i is loaded into the address latch. If either select is low, the latch keeps its value. While the latch holds 0..12, a selected read returns digit k from dig_rdata_i[4k+3:4k]. The order is: seconds units, seconds tens, minutes units, minutes tens, hours units, hours tens, weekday, day units, day tens, month units, month tens, year units, year tens.
- R3: A rising edge of wr_i while both chip selects are high and the address is 0..12 makes dig_wr_o equal to one-hot bit [address] for exactly one cycle, starting one cycle later. dig_wdata_o carries the nibble. Holding wr_i high produces no second strobe.
- R4: A write while either chip select is low, or to address 0xE or 0xF, gives no strobe.
- R5: bus_oe_o is high only while cs1_i, cs2_i and rd_i are all high. A read of address 0xD returns 0.
- R6: A selected read of address 0xE or 0xF returns the 1024 Hz wave on bit 0, the 1 Hz wave on bit 1, the minute wave on bit 2 and the hour wave on bit 3. Each wave is low for the first half of its period after it is cleared.
- R7: A selected write to address 0xD produces no digit strobe. It clears the sub-second divider to 0, which brings the 1 Hz wave and busy_o low, and leaves the oscillator-phase divider unchanged.
- R8: busy_o is high during the last BUSY_FAST fast periods of each second, and the second carry always falls inside that window. sec_tick_o pulses once per FAST_PER_SEC × TICKS_PER_FAST oscillator ticks.
- R9: While cs1_i is low, the prescaler keeps counting and second carries continue, but no bus access takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| osc_tick_i | input | 1 | One pulse per 32.768 kHz oscillator period |
| cs1_i | input | 1 | Chip select 1; when low, the block is in data-holding mode |
| cs2_i | input | 1 | Chip select 2 |
| adr_wr_i | input | 1 | Address load strobe |
| wr_i | input | 1 | Write strobe |
| rd_i | input | 1 | Read strobe |
| bus_i | input | 4 | Data pins, inbound |
| bus_o | output | 4 | Data pins, outbound |
| bus_oe_o | output | 1 | Output enable of the data pins |
| dig_rdata_i | input | 52 | Current value of the 13 digits, 4 bits each |
| dig_wr_o | output | 13 | One-hot digit write strobe |
| dig_wdata_o | output | 4 | Digit write data |
| sec_tick_o | output | 1 | Once-per-second carry to the counter chain |
| busy_o | output | 1 | Digits-changing window |

## Verification
The results fall due at three different times:
- Read data and bus_oe_o are combinational, so the bench samples them 1 ns after it raises rd_i at a falling edge.
- Address loads, digit write strobes and divider clears take effect at the next rising edge, so dig_wr_o is checked at the falling edge after that edge and again one cycle later for its return to zero.
- The prescaler only moves on cycles where osc_tick_i is high. The bench stops the ticks before every bus transaction and computes the expected wave levels from the total tick count, so each read sees a frozen, known divider state.

// File: rtl/rtc_host_pkg.sv
package rtc_host_pkg;
  localparam int unsigned NUM_DIGITS = 13;
  localparam logic [3:0]  ADR_CLR    = 4'hD;

  function automatic logic is_live(input logic [3:0] a);
    return a[3:1] == 3'b111;
  endfunction
endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
  parameter int unsigned TICKS_PER_FAST = 32,
  parameter int unsigned FAST_PER_SEC   = 1024,
  parameter int unsigned SEC_PER_MIN    = 60,
  parameter int unsigned MIN_PER_HR     = 60,
  parameter int unsigned BUSY_FAST      = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic sub_clr_i,
  output logic fast_lvl_o,
  output logic sec_lvl_o,
  output logic min_lvl_o,
  output logic hr_lvl_o,
  output logic sec_tick_o,
  output logic busy_o
);
  localparam int unsigned TW = (TICKS_PER_FAST > 2) ? $clog2(TICKS_PER_FAST) : 1;
  localparam int unsigned FW = (FAST_PER_SEC   > 2) ? $clog2(FAST_PER_SEC)   : 1;
  localparam int unsigned SW = (SEC_PER_MIN    > 2) ? $clog2(SEC_PER_MIN)    : 1;
  localparam int unsigned MW = (MIN_PER_HR     > 2) ? $clog2(MIN_PER_HR)     : 1;

  logic [TW-1:0] tick_cnt;
  logic [FW-1:0] fast_cnt;
  logic [SW-1:0] sec_cnt;
  logic [MW-1:0] min_cnt;
  logic          fast_tick, min_tick;

  assign fast_tick  = tick_i & (tick_cnt == TW'(TICKS_PER_FAST - 1));
  assign sec_tick_o = fast_tick & ~sub_clr_i & (fast_cnt == FW'(FAST_PER_SEC - 1));
  assign min_tick   = sec_tick_o & (sec_cnt == SW'(SEC_PER_MIN - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tick_cnt <= '0;
      fast_cnt <= '0;
      sec_cnt  <= '0;
      min_cnt  <= '0;
    end else begin
      if (tick_i) tick_cnt <= fast_tick ? '0 : tick_cnt + 1'b1;
      if (sub_clr_i)      fast_cnt <= '0;
      else if (fast_tick) fast_cnt <= sec_tick_o ? '0 : fast_cnt + 1'b1;
      if (sec_tick_o) sec_cnt <= min_tick ? '0 : sec_cnt + 1'b1;
      if (min_tick)   min_cnt <= (min_cnt == MW'(MIN_PER_HR - 1)) ? '0 : min_cnt + 1'b1;
    end
  end

  assign fast_lvl_o = tick_cnt >= TW'(TICKS_PER_FAST / 2);
  assign sec_lvl_o  = fast_cnt >= FW'(FAST_PER_SEC / 2);
  assign min_lvl_o  = sec_cnt  >= SW'(SEC_PER_MIN / 2);
  assign hr_lvl_o   = min_cnt  >= MW'(MIN_PER_HR / 2);
  // window covering the last BUSY_FAST fast periods before the carry
  assign busy_o     = fast_cnt >= FW'(FAST_PER_SEC - BUSY_FAST);
endmodule

// File: rtl/rtc_wr_decode.sv
module rtc_wr_decode
  import rtc_host_pkg::*;
(
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  wr_stb_i,
  input  logic [3:0]            adr_i,
  input  logic [3:0]            wdata_i,
  output logic                  clr_o,
  output logic [NUM_DIGITS-1:0] dig_wr_o,
  output logic [3:0]            dig_wdata_o
);
  logic [NUM_DIGITS-1:0] hit;

  for (genvar g = 0; g < NUM_DIGITS; g++) begin : g_hit
    assign hit[g] = wr_stb_i & (adr_i == 4'(g));
  end

  assign clr_o = wr_stb_i & (adr_i == ADR_CLR);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dig_wr_o    <= '0;
      dig_wdata_o <= '0;
    end else begin
      dig_wr_o <= hit;
      if (|hit) dig_wdata_o <= wdata_i;
    end
  end
endmodule

// File: rtl/rtc_rd_mux.sv
module rtc_rd_mux
  import rtc_host_pkg::*;
(
  input  logic [3:0]              adr_i,
  input  logic [NUM_DIGITS*4-1:0] dig_i,
  input  logic [3:0]              live_i,
  output logic [3:0]              data_o
);
  logic [3:0] dig_sel [NUM_DIGITS];

  for (genvar g = 0; g < NUM_DIGITS; g++) begin : g_dig
    assign dig_sel[g] = dig_i[4*g +: 4];
  end

  always_comb begin
    data_o = '0;
    if (is_live(adr_i)) data_o = live_i;
    for (int k = 0; k < NUM_DIGITS; k++)
      if (adr_i == 4'(k)) data_o = dig_sel[k];
  end
endmodule

// File: rtl/rtc_nibble_host.sv
module rtc_nibble_host
  import rtc_host_pkg::*;
#(
  parameter int unsigned TICKS_PER_FAST = 32,
  parameter int unsigned FAST_PER_SEC   = 1024,
  parameter int unsigned SEC_PER_MIN    = 60,
  parameter int unsigned MIN_PER_HR     = 60,
  parameter int unsigned BUSY_FAST      = 2
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      osc_tick_i,
  input  logic                      cs1_i,
  input  logic                      cs2_i,
  input  logic                      adr_wr_i,
  input  logic                      wr_i,
  input  logic                      rd_i,
  input  logic [3:0]                bus_i,
  output logic [3:0]                bus_o,
  output logic                      bus_oe_o,
  input  logic [NUM_DIGITS*4-1:0]   dig_rdata_i,
  output logic [NUM_DIGITS-1:0]     dig_wr_o,
  output logic [3:0]                dig_wdata_o,
  output logic                      sec_tick_o,
  output logic                      busy_o
);
  logic       sel, adr_wr_q, wr_q, adr_stb, wr_stb, clr;
  logic [3:0] adr_q, live;

  assign sel     = cs1_i & cs2_i;
  assign adr_stb = sel & adr_wr_i & ~adr_wr_q;
  assign wr_stb  = sel & wr_i & ~wr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      adr_wr_q <= 1'b0;
      wr_q     <= 1'b0;
      adr_q    <= '0;
    end else begin
      adr_wr_q <= adr_wr_i;
      wr_q     <= wr_i;
      if (adr_stb) adr_q <= bus_i;
    end
  end

  rtc_wr_decode u_wr (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wr_stb_i    (wr_stb),
    .adr_i       (adr_q),
    .wdata_i     (bus_i),
    .clr_o       (clr),
    .dig_wr_o    (dig_wr_o),
    .dig_wdata_o (dig_wdata_o)
  );

  rtc_prescaler #(
    .TICKS_PER_FAST (TICKS_PER_FAST),
    .FAST_PER_SEC   (FAST_PER_SEC),
    .SEC_PER_MIN    (SEC_PER_MIN),
    .MIN_PER_HR     (MIN_PER_HR),
    .BUSY_FAST      (BUSY_FAST)
  ) u_pre (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tick_i     (osc_tick_i),
    .sub_clr_i  (clr),
    .fast_lvl_o (live[0]),
    .sec_lvl_o  (live[1]),
    .min_lvl_o  (live[2]),
    .hr_lvl_o   (live[3]),
    .sec_tick_o (sec_tick_o),
    .busy_o     (busy_o)
  );

  rtc_rd_mux u_rd (
    .adr_i  (adr_q),
    .dig_i  (dig_rdata_i),
    .live_i (live),
    .data_o (bus_o)
  );

  assign bus_oe_o = sel & rd_i;
endmodule

// File: rtl/rtc_nibble_host_chk.sv
module rtc_nibble_host_chk
  import rtc_host_pkg::*;
(
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic                  cs1_i,
  input logic                  cs2_i,
  input logic                  rd_i,
  input logic                  bus_oe_o,
  input logic [NUM_DIGITS-1:0] dig_wr_o,
  input logic                  sec_tick_o,
  input logic                  busy_o
);
  // R5
  oe_only_sel_rd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_oe_o |-> (cs1_i && cs2_i && rd_i));
  // R3
  wr_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(dig_wr_o));
  // R3
  wr_single_cycle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dig_wr_o != '0) |=> (dig_wr_o == '0));
  // R8
  carry_in_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sec_tick_o |-> busy_o);
  // R9
  hold_no_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cs1_i |=> (dig_wr_o == '0));
endmodule

bind rtc_nibble_host rtc_nibble_host_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .cs1_i      (cs1_i),
  .cs2_i      (cs2_i),
  .rd_i       (rd_i),
  .bus_oe_o   (bus_oe_o),
  .dig_wr_o   (dig_wr_o),
  .sec_tick_o (sec_tick_o),
  .busy_o     (busy_o)
);

// File: tb/rtc_nibble_host_tb.sv
`timescale 1ns/1ps
module rtc_nibble_host_tb_top;
  localparam int ND = 13;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic osc_tick = 1'b0, cs1 = 1'b1, cs2 = 1'b1, adr_wr = 1'b0, wr = 1'b0, rd = 1'b0;
  logic [3:0] bus_in = '0;
  logic [3:0] bus_out, dig_wdata;
  logic bus_oe, sec_tick, busy;
  logic [ND*4-1:0] dig_rdata;
  logic [ND-1:0] dig_wr;

  int total = 0, bad = 0, sec_cnt = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  function automatic logic [3:0] dval(input int k);
    return 4'((k * 7 + 3) % 16);
  endfunction

  for (genvar g = 0; g < ND; g++) begin : g_rd
    assign dig_rdata[4*g +: 4] = dval(g);
  end

  rtc_nibble_host #(
    .TICKS_PER_FAST (4),
    .FAST_PER_SEC   (8),
    .SEC_PER_MIN    (6),
    .MIN_PER_HR     (4),
    .BUSY_FAST      (2)
  ) dut_i (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .osc_tick_i  (osc_tick),
    .cs1_i       (cs1),
    .cs2_i       (cs2),
    .adr_wr_i    (adr_wr),
    .wr_i        (wr),
    .rd_i        (rd),
    .bus_i       (bus_in),
    .bus_o       (bus_out),
    .bus_oe_o    (bus_oe),
    .dig_rdata_i (dig_rdata),
    .dig_wr_o    (dig_wr),
    .dig_wdata_o (dig_wdata),
    .sec_tick_o  (sec_tick),
    .busy_o      (busy)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic latch_addr(input logic [3:0] a);
    @(negedge clk); bus_in = a; adr_wr = 1'b1;
    @(negedge clk); adr_wr = 1'b0;
  endtask

  // returns strobe and data seen in the cycle after the write edge
  task automatic write_nib(input logic [3:0] d, output logic [ND-1:0] stb,
                           output logic [3:0] wd, output logic [ND-1:0] stb_after);
    @(negedge clk); bus_in = d; wr = 1'b1;
    @(negedge clk); stb = dig_wr; wd = dig_wdata; wr = 1'b0;
    @(negedge clk); stb_after = dig_wr;
  endtask

  task automatic read_nib(output logic [3:0] d, output logic oe);
    @(negedge clk); rd = 1'b1;
    #1; d = bus_out; oe = bus_oe;
    @(negedge clk); rd = 1'b0;
  endtask

  task automatic run_ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); osc_tick = 1'b1;
      #1; if (sec_tick) sec_cnt++;
    end
    @(negedge clk); osc_tick = 1'b0;
  endtask

  // {tick delta[15:6], live nibble {hr,min,sec,fast}[5:2], busy[1], pad[0]}
  localparam logic [15:0] VEC [7] = '{
    {10'd2,   4'b0001, 1'b0, 1'b0},
    {10'd15,  4'b0010, 1'b0, 1'b0},
    {10'd10,  4'b0011, 1'b1, 1'b0},
    {10'd71,  4'b0101, 1'b0, 1'b0},
    {10'd372, 4'b1011, 1'b0, 1'b0},
    {10'd230, 4'b1110, 1'b1, 1'b0},
    {10'd100, 4'b0000, 1'b0, 1'b0}
  };

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [3:0] d, wd;
    logic oe;
    logic [ND-1:0] stb, stb2;
    int n;

    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 oe", 32'(bus_oe), 0);
    check("R1 busy", 32'(busy), 0);
    check("R1 strobe", 32'(dig_wr), 0);
    check("R1 sec_tick", 32'(sec_tick), 0);
    rst_n = 1'b1;
    read_nib(d, oe);
    check("R1 reset addr reads digit 0", 32'(d), 32'(dval(0)));

    // R2 digit order readback
    for (int k = 0; k < ND; k++) begin
      latch_addr(4'(k));
      read_nib(d, oe);
      check("R2 digit read", 32'(d), 32'(dval(k)));
      check("R5 oe during read", 32'(oe), 1);
    end

    // R2 latch ignored when cs1 low
    latch_addr(4'd3);
    cs1 = 1'b0; latch_addr(4'd9); cs1 = 1'b1;
    read_nib(d, oe);
    check("R2 latch needs select", 32'(d), 32'(dval(3)));

    // R3 write strobe
    latch_addr(4'd7);
    write_nib(4'h5, stb, wd, stb2);
    check("R3 strobe", 32'(stb), 32'(1 << 7));
    check("R3 wdata", 32'(wd), 5);
    check("R3 single cycle", 32'(stb2), 0);
    latch_addr(4'd12);
    write_nib(4'hA, stb, wd, stb2);
    check("R3 strobe year tens", 32'(stb), 32'(1 << 12));

    // R3 held write gives one strobe
    latch_addr(4'd1);
    n = 0;
    @(negedge clk); bus_in = 4'h2; wr = 1'b1;
    for (int i = 0; i < 4; i++) begin @(negedge clk); if (dig_wr != '0) n++; end
    wr = 1'b0;
    check("R3 held write strobes once", 32'(n), 1);

    // R4 no strobe without cs2, nor to live addresses
    latch_addr(4'd2);
    cs2 = 1'b0; write_nib(4'h3, stb, wd, stb2); cs2 = 1'b1;
    check("R4 write needs cs2", 32'(stb), 0);
    latch_addr(4'hE);
    write_nib(4'h3, stb, wd, stb2);
    check("R4 no strobe at E", 32'(stb), 0);
    latch_addr(4'hF);
    write_nib(4'h3, stb, wd, stb2);
    check("R4 no strobe at F", 32'(stb), 0);

    // R5 bus drive rules
    latch_addr(4'd4);
    cs1 = 1'b0; read_nib(d, oe); cs1 = 1'b1;
    check("R5 no drive cs1 low", 32'(oe), 0);
    cs2 = 1'b0; read_nib(d, oe); cs2 = 1'b1;
    check("R5 no drive cs2 low", 32'(oe), 0);
    latch_addr(4'hD);
    read_nib(d, oe);
    check("R5 addr D reads 0", 32'(d), 0);

    // R6 / R8 vector table over the prescaler
    sec_cnt = 0;
    latch_addr(4'hE);
    foreach (VEC[i]) begin
      run_ticks(int'(VEC[i][15:6]));
      read_nib(d, oe);
      check("R6 live signals", 32'(d), 32'(VEC[i][5:2]));
      check("R8 busy window", 32'(busy), 32'(VEC[i][1]));
    end
    check("R8 second carries over 800 ticks", 32'(sec_cnt), 25);

    // R7 clear of sub-second divider
    run_ticks(27);
    read_nib(d, oe);
    check("R7 pre-clear live", 32'(d), 4'b0011);
    check("R7 pre-clear busy", 32'(busy), 1);
    latch_addr(4'hD);
    write_nib(4'h0, stb, wd, stb2);
    check("R7 no digit strobe", 32'(stb), 0);
    check("R7 busy cleared", 32'(busy), 0);
    latch_addr(4'hE);
    read_nib(d, oe);
    check("R7 post-clear live", 32'(d), 4'b0001);

    // R9 data-holding mode: counting continues, bus ignored
    sec_cnt = 0;
    cs1 = 1'b0;
    run_ticks(32);
    check("R9 carries while holding", 32'(sec_cnt), 1);
    read_nib(d, oe);
    check("R9 bus idle while holding", 32'(oe), 0);
    cs1 = 1'b1;
    latch_addr(4'hF);
    read_nib(d, oe);
    check("R9 R6 live at F after hold", 32'(d), 4'b0001);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule